// File: doc/BRIEF.md
# Scrambled Multi-Bank Request Spreader

This block sits between a reservation table, which has already merged repeat accesses, and a set of slow memory banks. It takes at most one request per cycle. Each request is a read or write flag, an address, write data and a slot tag. Before the block picks a bank, it passes the address through a keyed, invertible bit mix. The bank index is taken from the low bits of the mixed address, so a regular stride in the original addresses does not keep landing on the same bank.

Each bank has a small FIFO of depth K and a service port with valid and ready. A bank accepts one request and then stays busy for a programmable number of cycles before it can take the next one. This models a bank whose random access time is much longer than the arrival interval. Arrivals are never stalled. When a request reaches a bank whose FIFO is full, the request is dropped, a sticky overflow flag is raised, and the index of the first bank that overflowed is kept.

Top module: `bank_dispatcher`

## Requirements
- R1: After reset, no bank port asserts valid and the overflow flag is 0.
- R2: The address presented on a bank port is the mixed address P(a), built in three steps. First x = a XOR key. Then y = x XOR (x >> ADDR_W/2). Finally P is y rotated left by one bit. The request goes to bank number P[LOG_B-1:0]. The write flag, write data and tag pass through unchanged.
- R3: P is a bijection for any key. Across a sweep of all addresses, every mixed address appears exactly once.
- R4: For each bank, requests leave in the same order they were accepted.
- R5: A request captured on a clock edge into an empty, idle bank raises that bank's valid right after that same edge, and not before it.
- R6: A handshake (valid and ready both high) loads the bank's busy count from svc_cycles. The next handshake on that bank comes exactly svc_cycles+1 edges later when requests are waiting and ready stays high.
- R7: A request that reaches a bank holding K entries, in a cycle when that bank is not completing a handshake, is discarded. It also sets the overflow flag, which then stays set until reset. No overflow occurs while no FIFO is full.
- R8: ovf_bank holds the index of the bank that first overflowed. Later overflows do not change it.
- R9: While a bank's valid is high and its ready is low, valid stays high and the request on that port does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key | input | ADDR_W | Scramble key |
| svc_cycles | input | SVC_W | Busy cycles loaded on each handshake |
| in_valid | input | 1 | Request present this cycle |
| in_write | input | 1 | 1 = write, 0 = read |
| in_addr | input | ADDR_W | Request address |
| in_wdata | input | DATA_W | Write data |
| in_tag | input | TAG_W | Reservation slot tag |
| bk_valid | output | 2**LOG_B | Per-bank request valid |
| bk_ready | input | 2**LOG_B | Per-bank ready |
| bk_write | output | 2**LOG_B | Per-bank write flag |
| bk_addr | output | 2**LOG_B*ADDR_W | Per-bank mixed address, bank i in slice i |
| bk_wdata | output | 2**LOG_B*DATA_W | Per-bank write data |
| bk_tag | output | 2**LOG_B*TAG_W | Per-bank returned slot tag |
| ovf | output | 1 | Sticky overflow flag |
| ovf_bank | output | LOG_B | First bank that overflowed |

## Verification
A request is captured on the edge where in_valid is sampled. The target bank's valid rises right after that edge, and the overflow flag changes right after the capture edge of an overflowing request. A handshake takes effect on its edge, and that bank's next handshake falls svc_cycles+1 edges later. Inputs change just after a rising edge, and all outputs are read at the falling edge. Each result is therefore compared in the half cycle after the edge that produces it. The per-bank expected order and the handshake spacing are worked out from the tags and from a cycle counter kept in the bench.

// File: rtl/bank_dispatcher.sv
module bank_dispatcher #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 4,
  parameter int LOG_B  = 2,
  parameter int DEPTH  = 4,
  parameter int SVC_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             key,
  input  logic [SVC_W-1:0]              svc_cycles,
  input  logic                          in_valid,
  input  logic                          in_write,
  input  logic [ADDR_W-1:0]             in_addr,
  input  logic [DATA_W-1:0]             in_wdata,
  input  logic [TAG_W-1:0]              in_tag,
  output logic [(1<<LOG_B)-1:0]         bk_valid,
  input  logic [(1<<LOG_B)-1:0]         bk_ready,
  output logic [(1<<LOG_B)-1:0]         bk_write,
  output logic [(1<<LOG_B)*ADDR_W-1:0]  bk_addr,
  output logic [(1<<LOG_B)*DATA_W-1:0]  bk_wdata,
  output logic [(1<<LOG_B)*TAG_W-1:0]   bk_tag,
  output logic                          ovf,
  output logic [LOG_B-1:0]              ovf_bank
);
  localparam int NB   = 1 << LOG_B;
  localparam int HALF = ADDR_W / 2;
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int EW   = 1 + ADDR_W + DATA_W + TAG_W;

  logic [ADDR_W-1:0] mix1, mix2, perm;
  assign mix1 = in_addr ^ key;
  assign mix2 = mix1 ^ (mix1 >> HALF);
  assign perm = {mix2[ADDR_W-2:0], mix2[ADDR_W-1]};

  logic [LOG_B-1:0] sel;
  assign sel = perm[LOG_B-1:0];

  logic [EW-1:0] entry;
  assign entry = {in_write, perm, in_wdata, in_tag};

  logic [NB-1:0] drop_hit;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [EW-1:0]    mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic [SVC_W-1:0] busy;
    logic             hit, deq, full, enq;

    assign hit  = in_valid && (sel == LOG_B'(g));
    assign deq  = bk_valid[g] && bk_ready[g];
    assign full = (cnt == CW'(DEPTH));
    assign enq  = hit && (!full || deq);
    assign drop_hit[g] = hit && full && !deq;

    assign bk_valid[g] = (cnt != '0) && (busy == '0);
    assign {bk_write[g], bk_addr[g*ADDR_W +: ADDR_W],
            bk_wdata[g*DATA_W +: DATA_W], bk_tag[g*TAG_W +: TAG_W]} = mem[rp];

    always_ff @(posedge clk)
      if (enq) mem[wp] <= entry;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp   <= '0;
        rp   <= '0;
        cnt  <= '0;
        busy <= '0;
      end else begin
        if (enq) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
        if (deq) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
        if (enq && !deq)      cnt <= cnt + 1'b1;
        else if (deq && !enq) cnt <= cnt - 1'b1;
        if (deq)               busy <= svc_cycles;
        else if (busy != '0)   busy <= busy - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf      <= 1'b0;
      ovf_bank <= '0;
    end else if ((|drop_hit) && !ovf) begin
      ovf      <= 1'b1;
      ovf_bank <= sel;
    end
  end
endmodule

// File: rtl/bank_dispatcher_sva.sv
module bank_dispatcher_sva #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 4,
  parameter int LOG_B  = 2,
  parameter int SVC_W  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [SVC_W-1:0]              svc_cycles,
  input logic [(1<<LOG_B)-1:0]         bk_valid,
  input logic [(1<<LOG_B)-1:0]         bk_ready,
  input logic [(1<<LOG_B)-1:0]         bk_write,
  input logic [(1<<LOG_B)*ADDR_W-1:0]  bk_addr,
  input logic [(1<<LOG_B)*DATA_W-1:0]  bk_wdata,
  input logic [(1<<LOG_B)*TAG_W-1:0]   bk_tag,
  input logic                          ovf,
  input logic [LOG_B-1:0]              ovf_bank
);
  localparam int NB = 1 << LOG_B;

  for (genvar g = 0; g < NB; g++) begin : g_chk
    a_r2_bank_bits: assert property (@(posedge clk) disable iff (!rst_n)
      bk_valid[g] |-> bk_addr[g*ADDR_W +: LOG_B] == LOG_B'(g));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      bk_valid[g] && !bk_ready[g] |=> bk_valid[g]
        && $stable(bk_addr[g*ADDR_W +: ADDR_W])
        && $stable(bk_wdata[g*DATA_W +: DATA_W])
        && $stable(bk_tag[g*TAG_W +: TAG_W])
        && $stable(bk_write[g]));

    a_r6_busy_gap: assert property (@(posedge clk) disable iff (!rst_n)
      bk_valid[g] && bk_ready[g] && svc_cycles != '0 |=> !bk_valid[g]);
  end

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  a_r8_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> $stable(ovf_bank));
endmodule

bind bank_dispatcher bank_dispatcher_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .LOG_B(LOG_B), .SVC_W(SVC_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .svc_cycles(svc_cycles),
  .bk_valid(bk_valid), .bk_ready(bk_ready), .bk_write(bk_write),
  .bk_addr(bk_addr), .bk_wdata(bk_wdata), .bk_tag(bk_tag),
  .ovf(ovf), .ovf_bank(ovf_bank)
);

// File: tb/sim_bank_dispatcher.sv
`timescale 1ns/1ps
module sim_bank_dispatcher;
  localparam int QD = 300;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  key = 8'h5A;
  logic [3:0]  svc_cycles = 0;
  logic        in_valid = 0, in_write = 0;
  logic [7:0]  in_addr = 0, in_wdata = 0;
  logic [3:0]  in_tag = 0;
  logic [3:0]  bk_valid, bk_ready = 0, bk_write;
  logic [31:0] bk_addr, bk_wdata;
  logic [15:0] bk_tag;
  logic        ovf;
  logic [1:0]  ovf_bank;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  logic [20:0] mq [4][QD];
  int mh [4], mt [4];
  bit seen [256];
  int hs_n [4];
  int hs_c [4][4];

  bank_dispatcher u0 (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pmix(input logic [7:0] a, input logic [7:0] k);
    logic [7:0] x;
    x = a ^ k;
    x = x ^ (x >> 4);
    return {x[6:0], x[7]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_for(input int bank, input int n);
    int found = 0;
    for (int a = 0; a < 256; a++)
      if (pmix(a[7:0], key) % 4 == bank) begin
        if (found == n) return a[7:0];
        found++;
      end
    return 8'h00;
  endfunction

  task automatic send(input logic w, input logic [7:0] a, input logic [7:0] d,
                      input logic [3:0] t, input bit drop);
    int b;
    logic [7:0] p;
    p = pmix(a, key);
    b = p % 4;
    in_valid = 1; in_write = w; in_addr = a; in_wdata = d; in_tag = t;
    if (!drop) begin
      mq[b][mt[b] % QD] = {w, p, d, t};
      mt[b]++;
    end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    for (int b = 0; b < 4; b++)
      if (bk_valid[b] && bk_ready[b]) begin
        logic [20:0] got;
        got = {bk_write[b], bk_addr[b*8 +: 8], bk_wdata[b*8 +: 8], bk_tag[b*4 +: 4]};
        if (mh[b] == mt[b]) chk(0, "R4 unexpected request", got, 0);
        else begin
          chk(got == mq[b][mh[b] % QD], "R2/R4 bank port contents", got, mq[b][mh[b] % QD]);
          mh[b]++;
        end
        chk(!seen[bk_addr[b*8 +: 8]], "R3 mixed address repeated", bk_addr[b*8 +: 8], 0);
        seen[bk_addr[b*8 +: 8]] = 1;
        if (hs_n[b] < 4) hs_c[b][hs_n[b]] = cyc;
        hs_n[b]++;
      end
  end

  task automatic clear_seen();
    for (int i = 0; i < 256; i++) seen[i] = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int b = 0; b < 4; b++) begin mh[b] = 0; mt[b] = 0; hs_n[b] = 0; end
    clear_seen();
    wait_cyc(3);
    rst_n = 1;
    @(negedge clk);
    chk(bk_valid == 4'h0, "R1 valid after reset", bk_valid, 0);
    chk(ovf == 1'b0, "R1 ovf after reset", ovf, 0);
    @(posedge clk); #1;

    // R2 R3 R4: full address sweep, all banks ready, no busy time
    bk_ready = 4'hF; svc_cycles = 0;
    for (int a = 0; a < 256; a++) send(a[0], a[7:0], ~a[7:0], a[3:0], 0);
    wait_cyc(10);
    begin
      int n = 0;
      for (int i = 0; i < 256; i++) n += seen[i];
      chk(n == 256, "R3 all mixed addresses seen", n, 256);
    end
    for (int b = 0; b < 4; b++) chk(mh[b] == mt[b], "R4 bank drained", mh[b], mt[b]);
    chk(ovf == 0, "R7 no overflow without full FIFO", ovf, 0);

    // R5 R9: latency and hold while not ready
    clear_seen();
    bk_ready = 4'h0;
    begin
      logic [7:0] a, p;
      int b;
      a = addr_for(1, 0); p = pmix(a, key); b = p % 4;
      in_valid = 1; in_write = 1; in_addr = a; in_wdata = 8'hC3; in_tag = 4'h9;
      mq[b][mt[b] % QD] = {1'b1, p, 8'hC3, 4'h9}; mt[b]++;
      @(negedge clk);
      chk(bk_valid[b] == 0, "R5 valid not before capture", bk_valid[b], 0);
      @(posedge clk); #1; in_valid = 0;
      @(negedge clk);
      chk(bk_valid[b] == 1, "R5 valid right after capture", bk_valid[b], 1);
      repeat (5) @(negedge clk);
      chk(bk_valid[b] == 1, "R9 valid held", bk_valid[b], 1);
      chk(bk_addr[b*8 +: 8] == p, "R9 address held", bk_addr[b*8 +: 8], p);
      chk(bk_tag[b*4 +: 4] == 4'h9, "R9 tag held", bk_tag[b*4 +: 4], 9);
      @(posedge clk); #1;
      bk_ready = 4'hF;
      wait_cyc(4);
      chk(mh[b] == mt[b], "R9 held request delivered", mh[b], mt[b]);
    end

    // R6: service spacing for each busy count 0..3
    for (int s = 0; s < 4; s++) begin
      int b = s;
      clear_seen();
      svc_cycles = s[3:0];
      hs_n[b] = 0;
      for (int n = 0; n < 3; n++) send(0, addr_for(b, n + 4), 8'h10 + n[7:0], n[3:0], 0);
      wait_cyc(20);
      chk(hs_n[b] == 3, "R6 handshake count", hs_n[b], 3);
      chk(hs_c[b][1] - hs_c[b][0] == s + 1, "R6 spacing first", hs_c[b][1] - hs_c[b][0], s + 1);
      chk(hs_c[b][2] - hs_c[b][1] == s + 1, "R6 spacing second", hs_c[b][2] - hs_c[b][1], s + 1);
    end

    // R7 R8: overflow on bank 2, then bank 3
    clear_seen();
    svc_cycles = 0;
    bk_ready = 4'h0;
    for (int n = 0; n < 4; n++) send(1, addr_for(2, n), 8'hA0 + n[7:0], n[3:0], 0);
    @(negedge clk);
    chk(ovf == 0, "R7 no overflow at exactly K", ovf, 0);
    @(posedge clk); #1;
    send(1, addr_for(2, 4), 8'hEE, 4'hE, 1);
    @(negedge clk);
    chk(ovf == 1, "R7 overflow raised", ovf, 1);
    chk(ovf_bank == 2'd2, "R8 first overflow bank", ovf_bank, 2);
    @(posedge clk); #1;
    for (int n = 0; n < 4; n++) send(0, addr_for(3, n), 8'hB0 + n[7:0], 4'h8 + n[3:0], 0);
    send(0, addr_for(3, 4), 8'hEF, 4'hF, 1);
    @(negedge clk);
    chk(ovf_bank == 2'd2, "R8 bank kept on later overflow", ovf_bank, 2);
    @(posedge clk); #1;
    bk_ready = 4'hF;
    wait_cyc(20);
    for (int b = 0; b < 4; b++) chk(mh[b] == mt[b], "R7 only kept requests delivered", mh[b], mt[b]);
    chk(ovf == 1, "R7 overflow sticky", ovf, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule